// File: doc/BRIEF.md
# Dual-Compare Timer with Per-Channel Action Masks

This block is an 8-bit up-counter with two compare channels. Each channel holds a compare value and a 4-bit mode word. When the counter takes a value equal to a channel's compare value, that channel produces a match event. The mode word decides what the event does:

- raise an interrupt request;
- clear the counter;
- flip a toggle flip-flop that both channels share;
- fire once and then stay quiet until it is re-armed (one-shot behaviour).

The counter does not run on its own clock. It advances on one of four enable pulses, each one system clock wide, chosen by a 2-bit source select. Software sets the block up through a small register port with a registered read path. The block also exports the match pulses of each channel, so that they can drive a following counter stage or a serial clock.

Top module: `dual_cmp_timer`

## Requirements
- R1: After the synchronous reset, all of the following hold:
  - the counter, both compare values, both mode words, the source select and the pending flags are zero;
  - both channels are armed;
  - `irq`, `tog_out` and `match` are low.
- R2: The counter changes only in a cycle where `tick_src[sel]` is high. `sel` is the source-select field, and `tick_src` bits 3, 2, 1 and 0 are the system clock, the second timer, the first timer and the external edge. In such a cycle the counter advances by one, wrapping from 255 to 0. Pulses on the unselected bits have no effect.
- R3: When a tick makes the counter equal to channel i's compare value and the channel is active, `match[i]` is high for exactly the one cycle after that edge. At that time the counter reads back as the compare value.
- R4: Mode word bits are: bit 3 one-shot, bit 2 toggle, bit 1 counter clear, bit 0 interrupt. With a mode word of 0000b, a match pulses `match[i]` and has no other effect.
- R5: Each match with bit 2 set inverts `tog_out` on the match edge. Two such matches on the same edge leave `tog_out` unchanged.
- R6: A match with bit 1 set makes the next selected tick load 0 instead of the count plus one.
- R7: A match with bit 0 set sets that channel's pending flag, so `irq` (the OR of the flags) goes high on the match edge and stays high. Writing the status register with data bit i = 1 clears flag i. A new match on the same edge takes priority over the clear.
- R8: With bit 3 set, a channel goes disarmed at its first match. While disarmed, the channel produces no match pulse and no action. Writing its mode word with bit 3 = 1 re-arms it.
- R9: Register map (writes to addresses 6 and 7 are ignored). `rd_data` shows the addressed value one cycle after `rd_addr`.

  | Address | Contents |
  |---|---|
  | 0 | compare value, channel 0 |
  | 1 | compare value, channel 1 |
  | 2 | mode word, channel 0 |
  | 3 | mode word, channel 1 |
  | 4 | source select, bits 1:0 |
  | 5 | pending flags, bits 1:0 (write 1 to clear) |
  | 6 | counter (read only) |
  | 7 | armed flags, bits 1:0 (read only) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| tick_src | input | 4 | Counting enable pulses, one per source |
| irq | output | 1 | Interrupt request, held until cleared |
| tog_out | output | 1 | Shared toggle flip-flop |
| match | output | 2 | Per-channel match pulses |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and four clock sources. At this width, a full wrap from 255 to 0 takes only 256 selected ticks, and random compare values are hit often. Both channels can therefore land on the same count in the same cycle, and one-shot channels are disarmed and re-armed many times within a short run. A cycle-level model in the bench predicts every output and readback value under random register writes and random source pulses.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH   = 2;
  localparam int MODE_W   = 4;
  localparam int ADDR_W   = 3;
  localparam int M_ONCE   = 3;
  localparam int M_TOG    = 2;
  localparam int M_CLR    = 1;
  localparam int M_IRQ    = 0;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd6;
  localparam logic [ADDR_W-1:0] A_ARM   = 3'd7;
endpackage

// File: rtl/dct_clksel.sv
module dct_clksel #(
  parameter int NSRC = 4,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             en
);
  generate
    if ((1 << SEL_W) == NSRC) begin : g_pow2
      assign en = src[sel];
    end else begin : g_odd
      assign en = (int'(sel) < NSRC) ? src[sel] : 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] nxt
);
  logic clr_pend_q;

  assign nxt = clr_pend_q ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      clr_pend_q <= 1'b0;
    end else if (en) begin
      cnt_q      <= nxt;
      clr_pend_q <= clr_req;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr_pend_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R6
  zero_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (en && clr_pend_q) |=> cnt_q == '0);
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [CNT_W-1:0]          nxt,
  input  logic [CNT_W-1:0]          cnt_q,
  input  logic [CNT_W-1:0]          cmp_q,
  input  logic [dct_pkg::MODE_W-1:0] mode_q,
  input  logic                      rearm,
  output logic                      hit,
  output logic                      hit_q,
  output logic                      armed_q
);
  import dct_pkg::*;

  assign hit = en && (nxt == cmp_q) && (!mode_q[M_ONCE] || armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      hit_q <= hit;
      if (rearm)                    armed_q <= 1'b1;
      else if (hit && mode_q[M_ONCE]) armed_q <= 1'b0;
    end
  end

  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[M_ONCE] && !armed_q) |=> !hit_q);
  // R3
  match_val_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> cnt_q == $past(cmp_q));
endmodule

// File: rtl/dct_regs.sv
module dct_regs #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        wr_en,
  input  logic [dct_pkg::ADDR_W-1:0]                  wr_addr,
  input  logic [CNT_W-1:0]                            wr_data,
  input  logic [dct_pkg::ADDR_W-1:0]                  rd_addr,
  input  logic [CNT_W-1:0]                            cnt_q,
  input  logic [dct_pkg::NUM_CH-1:0]                  armed_q,
  input  logic [dct_pkg::NUM_CH-1:0]                  irq_hit,
  output logic [dct_pkg::NUM_CH-1:0][CNT_W-1:0]       cmp_q,
  output logic [dct_pkg::NUM_CH-1:0][dct_pkg::MODE_W-1:0] mode_q,
  output logic [dct_pkg::NUM_CH-1:0]                  rearm,
  output logic [SEL_W-1:0]                            sel_q,
  output logic [dct_pkg::NUM_CH-1:0]                  pend_q,
  output logic [CNT_W-1:0]                            rd_data
);
  import dct_pkg::*;

  localparam logic [ADDR_W-1:0] CMP_BASE  = A_CMP0;
  localparam logic [ADDR_W-1:0] MODE_BASE = A_MODE0;

  logic [NUM_CH-1:0] clr;
  logic [CNT_W-1:0]  rd_nxt;

  assign clr = (wr_en && wr_addr == A_STAT) ? wr_data[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_A  = CMP_BASE + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] MODE_A = MODE_BASE + ADDR_W'(i);

    assign rearm[i] = wr_en && wr_addr == MODE_A && wr_data[M_ONCE];

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[i]  <= '0;
        mode_q[i] <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr_en && wr_addr == CMP_A)  cmp_q[i]  <= wr_data;
        if (wr_en && wr_addr == MODE_A) mode_q[i] <= wr_data[MODE_W-1:0];
        if (irq_hit[i])                 pend_q[i] <= 1'b1;
        else if (clr[i])                pend_q[i] <= 1'b0;
      end
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!irq_hit[i] && !clr[i]) |=> $stable(pend_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)                          sel_q <= '0;
    else if (wr_en && wr_addr == A_SEL) sel_q <= wr_data[SEL_W-1:0];
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      A_CMP0:  rd_nxt = cmp_q[0];
      A_CMP1:  rd_nxt = cmp_q[1];
      A_MODE0: rd_nxt = {{(CNT_W-MODE_W){1'b0}}, mode_q[0]};
      A_MODE1: rd_nxt = {{(CNT_W-MODE_W){1'b0}}, mode_q[1]};
      A_SEL:   rd_nxt = {{(CNT_W-SEL_W){1'b0}}, sel_q};
      A_STAT:  rd_nxt = {{(CNT_W-NUM_CH){1'b0}}, pend_q};
      A_CNT:   rd_nxt = cnt_q;
      A_ARM:   rd_nxt = {{(CNT_W-NUM_CH){1'b0}}, armed_q};
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CNT_W = 8,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [NSRC-1:0]  tick_src,
  output logic             irq,
  output logic             tog_out,
  output logic [1:0]       match
);
  import dct_pkg::*;

  localparam int SEL_W = $clog2(NSRC);

  logic                               en;
  logic [CNT_W-1:0]                   cnt_q;
  logic [CNT_W-1:0]                   nxt;
  logic [NUM_CH-1:0][CNT_W-1:0]       cmp_q;
  logic [NUM_CH-1:0][MODE_W-1:0]      mode_q;
  logic [NUM_CH-1:0]                  rearm;
  logic [SEL_W-1:0]                   sel_q;
  logic [NUM_CH-1:0]                  pend_q;
  logic [NUM_CH-1:0]                  hit;
  logic [NUM_CH-1:0]                  hit_q;
  logic [NUM_CH-1:0]                  armed_q;
  logic [NUM_CH-1:0]                  irq_hit;
  logic [NUM_CH-1:0]                  clr_hit;
  logic [NUM_CH-1:0]                  tog_hit;
  logic                               tog_q;

  dct_clksel #(.NSRC(NSRC)) u_sel (
    .src(tick_src), .sel(sel_q), .en(en)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .clr_req(|clr_hit),
    .cnt_q(cnt_q), .nxt(nxt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .en(en), .nxt(nxt), .cnt_q(cnt_q),
      .cmp_q(cmp_q[i]), .mode_q(mode_q[i]), .rearm(rearm[i]),
      .hit(hit[i]), .hit_q(hit_q[i]), .armed_q(armed_q[i])
    );
    assign irq_hit[i] = hit[i] && mode_q[i][M_IRQ];
    assign clr_hit[i] = hit[i] && mode_q[i][M_CLR];
    assign tog_hit[i] = hit[i] && mode_q[i][M_TOG];
  end

  dct_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt_q(cnt_q),
    .armed_q(armed_q), .irq_hit(irq_hit), .cmp_q(cmp_q),
    .mode_q(mode_q), .rearm(rearm), .sel_q(sel_q),
    .pend_q(pend_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_q ^ (^tog_hit);
  end

  assign tog_out = tog_q;
  assign irq     = |pend_q;
  assign match   = hit_q;

  // R5
  tog_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tog_q) |-> |hit_q);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> |hit_q);
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [3:0] tick_src;
  logic [7:0] rd_data;
  logic       irq, tog_out;
  logic [1:0] match;

  dual_cmp_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_src(tick_src), .irq(irq), .tog_out(tog_out), .match(match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected state, derived from the requirements
  logic [7:0] m_cnt;
  logic       m_clrp;
  logic [1:0] m_armed, m_pend, m_match;
  logic       m_tog;
  logic [1:0] m_sel;
  logic [7:0] m_cmp [2];
  logic [3:0] m_mode [2];
  logic [7:0] m_rd;
  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [7:0] rd_of(logic [2:0] a);
    case (a)
      3'd0: return m_cmp[0];
      3'd1: return m_cmp[1];
      3'd2: return {4'd0, m_mode[0]};
      3'd3: return {4'd0, m_mode[1]};
      3'd4: return {6'd0, m_sel};
      3'd5: return {6'd0, m_pend};
      3'd6: return m_cnt;
      default: return {6'd0, m_armed};
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_clrp = 0; m_armed = 2'b11; m_pend = 0; m_match = 0;
    m_tog = 0; m_sel = 0; m_rd = 0;
    for (int i = 0; i < 2; i++) begin m_cmp[i] = 0; m_mode[i] = 0; end
  endtask

  // one cycle: drive at negedge, predict, check at the next negedge
  task automatic step(string tag, bit we, logic [2:0] wa, logic [7:0] wd,
                      logic [2:0] ra, logic [3:0] tk);
    logic       en;
    logic [7:0] nx;
    logic [1:0] hit, arm_n, pend_n, clr;
    logic [7:0] rd_n;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; tick_src = tk;
    en = tk[m_sel];
    nx = m_clrp ? 8'd0 : m_cnt + 8'd1;
    arm_n = m_armed;
    for (int i = 0; i < 2; i++) begin
      hit[i] = en && nx == m_cmp[i] && (!m_mode[i][3] || m_armed[i]);
      if (hit[i] && m_mode[i][3]) arm_n[i] = 1'b0;
      if (we && wa == 3'(2 + i) && wd[3]) arm_n[i] = 1'b1;
    end
    clr = (we && wa == 3'd5) ? wd[1:0] : 2'b00;
    pend_n = m_pend;
    for (int i = 0; i < 2; i++) begin
      if (hit[i] && m_mode[i][0]) pend_n[i] = 1'b1;
      else if (clr[i])            pend_n[i] = 1'b0;
    end
    rd_n = rd_of(ra);
    @(negedge clk);
    if (en) begin
      m_cnt  = nx;
      m_clrp = (hit[0] && m_mode[0][1]) || (hit[1] && m_mode[1][1]);
    end
    m_tog   = m_tog ^ (hit[0] && m_mode[0][2]) ^ (hit[1] && m_mode[1][2]);
    m_armed = arm_n;
    m_pend  = pend_n;
    m_match = hit;
    m_rd    = rd_n;
    if (we) begin
      case (wa)
        3'd0: m_cmp[0]  = wd;
        3'd1: m_cmp[1]  = wd;
        3'd2: m_mode[0] = wd[3:0];
        3'd3: m_mode[1] = wd[3:0];
        3'd4: m_sel     = wd[1:0];
        default: ;
      endcase
    end
    chk(tag, "match",   int'(match),   int'(m_match));
    chk(tag, "tog_out", int'(tog_out), int'(m_tog));
    chk(tag, "irq",     int'(irq),     int'(|m_pend));
    chk(tag, "rd_data", int'(rd_data), int'(m_rd));
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [7:0] d);
    step(tag, 1'b1, a, d, 3'd6, 4'd0);
  endtask

  task automatic tick(string tag, int n, logic [3:0] tk);
    for (int k = 0; k < n; k++) step(tag, 1'b0, 3'd0, 8'd0, 3'd6, tk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; tick_src = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();

    // R1: reset state on every readback address and all outputs
    for (int a = 0; a < 8; a++) step("R1", 1'b0, 3'd0, 8'd0, 3'(a), 4'd0);
    step("R1", 1'b0, 3'd0, 8'd0, 3'd7, 4'd0);
    chk("R1", "armed readback", int'(rd_data), 3);

    // R2: select 0 = external edge; other sources ignored
    tick("R2", 4, 4'b1110);
    tick("R2", 3, 4'b0001);
    chk("R2", "count after ext ticks", int'(rd_data), 2);
    wr("R2", 3'd4, 8'd2);
    tick("R2", 3, 4'b1011);
    tick("R2", 2, 4'b0100);
    wr("R2", 3'd4, 8'd3);
    tick("R2", 2, 4'b1000);

    // R9: readback of written registers; writes to 6 and 7 ignored
    wr("R9", 3'd0, 8'd40);
    wr("R9", 3'd1, 8'd200);
    wr("R9", 3'd6, 8'd99);
    wr("R9", 3'd7, 8'd0);
    for (int a = 0; a < 8; a++) step("R9", 1'b0, 3'd0, 8'd0, 3'(a), 4'd0);

    // R3/R4: mode 0000b pulses match only; R6 wrap 255->0 without clear
    tick("R4", 300, 4'b1000);

    // R6: clear on channel 0 at 40
    wr("R6", 3'd2, 8'b0010);
    tick("R6", 90, 4'b1000);

    // R5: both channels toggle at the same count -> no net change
    wr("R5", 3'd1, 8'd40);
    wr("R5", 3'd2, 8'b0110);
    wr("R5", 3'd3, 8'b0100);
    tick("R5", 90, 4'b1000);
    wr("R5", 3'd3, 8'b0000);
    tick("R5", 90, 4'b1000);

    // R7: interrupt held, clear by status write, set wins over clear
    wr("R7", 3'd2, 8'b0011);
    tick("R7", 50, 4'b1000);
    wr("R7", 3'd5, 8'h03);
    tick("R7", 39, 4'b1000);
    step("R7", 1'b1, 3'd5, 8'h03, 3'd5, 4'b1000);

    // R8: one-shot channel goes quiet, then re-armed by mode write
    wr("R8", 3'd2, 8'b1111);
    tick("R8", 120, 4'b1000);
    step("R8", 1'b0, 3'd0, 8'd0, 3'd7, 4'd0);
    wr("R8", 3'd2, 8'b1110);
    tick("R8", 120, 4'b1000);
    wr("R8", 3'd5, 8'h03);

    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic       we;
      logic [2:0] wa;
      logic [7:0] wd;
      we = ($urandom % 8) == 0;
      wa = 3'($urandom % 8);
      wd = 8'($urandom);
      if (wa == 3'd0 || wa == 3'd1) wd = 8'($urandom % 24);
      step("R3", we, wa, wd, 3'($urandom % 8), 4'($urandom));
    end

    summary();
  end
endmodule